// File: doc/BRIEF.md
# Folded Word Memory with Predecoded Rows

This block is a synchronous single-port memory of 2^ADDR_W words, each DATA_W bits wide. Internally the words are not kept as one tall array. They are packed into a short, wide array. Each physical row holds 2^COL_BITS words side by side, so the array has 2^(ADDR_W-COL_BITS) rows and DATA_W·2^COL_BITS columns.

The upper address bits pick a row. They pass through a predecoder that turns each pair of bits into four one-hot lines. Each word line is then the AND of one line from every group. The lower COL_BITS address bits drive a column stage. On a read, a column multiplexer per output bit takes one word out of the row. On a write, a column write-enable decoder restricts the update to the columns of that one word.

Inside a row the bits are interleaved. Bit j of the word with column select s lives at column j·2^COL_BITS + s, so each output bit has its own narrow multiplexer over neighbouring columns. A client drives an address with a write enable and data, and receives the addressed word on the read port one clock after a read is issued.

Top module: `folded_mem`

## Requirements
- R1: The address is split as {row, column select}: row = addr[ADDR_W-1:COL_BITS] and column select = addr[COL_BITS-1:0]. Every one of the 2^ADDR_W addresses, including 0 and all-ones, reaches its own word.
- R2: On a rising edge with rst_n high and we low, the word at addr is captured. rd_data shows that word from just after that edge until the next read edge. Before the edge, rd_data still shows the previous result.
- R3: On a rising edge with rst_n high and we high, wr_data is stored at addr. A later read of that address returns it.
- R4: A write changes only the DATA_W columns of the addressed word. The other words that share its row keep their contents.
- R5: rd_data holds its value across a write cycle.
- R6: Reset is synchronous and active low. A rising edge with rst_n low sets rd_data to zero, and no write happens on that edge. Stored words survive a reset.
- R7: For any address exactly one word line is active, so distinct addresses never alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address: row bits above, column-select bits below |
| we | input | 1 | 1 = write wr_data at addr, 0 = read addr |
| wr_data | input | DATA_W | Word to store on a write |
| rd_data | output | DATA_W | Word returned by the most recent read |

## Verification
The hardest case to reach from the ports is a word being corrupted by a write to one of its row neighbours. The neighbours share a word line and differ only in the column-select bits. A plain write-then-read of each address can miss such corruption.

To catch it, the stimulus walks every row and every column-select value. After each write it reads back all the words of that row, and it compares them with a flat array kept in the bench. Every write uses a new value that depends on the address and the pass number, so a stray column write changes a neighbour's value and the mismatch is visible.

// File: rtl/folded_mem_pkg.sv
// Package of shared helpers for the folded memory.
// Assumes: called only with constant arguments at elaboration time.
package folded_mem_pkg;

    // Number of two-bit predecode groups that cover a row address.
    function automatic int unsigned pre_groups(int unsigned row_bits);
        return (row_bits + 1) / 2;
    endfunction

    // Physical column that holds bit bit_idx of the word with column select word_sel.
    function automatic int unsigned col_of(int unsigned bit_idx, int unsigned word_sel,
                                           int unsigned col_bits);
        return bit_idx * (1 << col_bits) + word_sel;
    endfunction

endpackage

// File: rtl/fm_predecoder.sv
// Row-address predecoder. Each pair of row bits becomes four one-hot lines.
// When ROW_BITS is odd, the last group decodes a single bit onto its
// lines 0 and 1, and its lines 2 and 3 stay low.
// Assumes: ROW_BITS >= 1.
module fm_predecoder
    import folded_mem_pkg::*;
#(
    parameter int ROW_BITS = 6,
    localparam int NGRP    = pre_groups(ROW_BITS)
) (
    input  logic [ROW_BITS-1:0] row_addr,
    output logic [NGRP*4-1:0]   pre_lines
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (2 * g + 1 < ROW_BITS) begin : g_pair
            // Expand two row bits into four one-hot lines.
            always_comb begin
                for (int i = 0; i < 4; i++) begin
                    pre_lines[g*4 + i] = (row_addr[2*g +: 2] == 2'(i));
                end
            end
        end else begin : g_single
            // Expand the lone top bit into two lines.
            always_comb begin
                pre_lines[g*4 + 0] = ~row_addr[2*g];
                pre_lines[g*4 + 1] = row_addr[2*g];
                pre_lines[g*4 + 2] = 1'b0;
                pre_lines[g*4 + 3] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/fm_row_decoder.sv
// Final row decoder. Word line r is the AND of one predecoded line per
// group. Within group g it uses the line numbered by bits [2g+1:2g] of r.
// Assumes: pre_lines is one-hot within every group.
module fm_row_decoder
    import folded_mem_pkg::*;
#(
    parameter int ROW_BITS = 6,
    localparam int NGRP    = pre_groups(ROW_BITS),
    localparam int ROWS    = 1 << ROW_BITS
) (
    input  logic [NGRP*4-1:0] pre_lines,
    output logic [ROWS-1:0]   wordline
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // AND one line taken from each predecode group.
        always_comb begin
            logic acc;
            acc = 1'b1;
            for (int g = 0; g < NGRP; g++) begin
                acc = acc & pre_lines[g*4 + ((r >> (2*g)) & 3)];
            end
            wordline[r] = acc;
        end
    end

endmodule

// File: rtl/fm_col_driver.sv
// Column write driver. It enables only the columns of the selected word and
// fans each data bit out to its interleaved columns.
// Assumes: COL_BITS >= 1.
module fm_col_driver
    import folded_mem_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int COL_BITS = 2,
    localparam int NSEL    = 1 << COL_BITS,
    localparam int COLS    = DATA_W * NSEL
) (
    input  logic                we,
    input  logic [COL_BITS-1:0] col_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [COLS-1:0]     col_wen,
    output logic [COLS-1:0]     col_wdata
);

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        for (genvar w = 0; w < NSEL; w++) begin : g_sel
            localparam int C = col_of(j, w, COL_BITS);
            // Enable this column only for the selected word, and give it data bit j.
            always_comb begin
                col_wen[C]   = we && (col_sel == COL_BITS'(w));
                col_wdata[C] = wr_data[j];
            end
        end
    end

endmodule

// File: rtl/fm_col_mux.sv
// Column read multiplexer. It uses one 2^COL_BITS:1 mux per output bit,
// each choosing among that bit's adjacent interleaved columns.
// Assumes: the row vector uses the interleave of col_of().
module fm_col_mux #(
    parameter int DATA_W   = 8,
    parameter int COL_BITS = 2,
    localparam int NSEL    = 1 << COL_BITS,
    localparam int COLS    = DATA_W * NSEL
) (
    input  logic [COLS-1:0]     row_bits,
    input  logic [COL_BITS-1:0] col_sel,
    output logic [DATA_W-1:0]   word
);

    for (genvar j = 0; j < DATA_W; j++) begin : g_bit
        logic [NSEL-1:0] grp;
        // Choose bit j of the selected word from its column group.
        always_comb begin
            grp     = row_bits[j*NSEL +: NSEL];
            word[j] = grp[col_sel];
        end
    end

endmodule

// File: rtl/fm_cell_array.sv
// Storage array of ROWS x COLS bits with a registered row read.
// A write updates the cells where the word line and the column enable are
// both set. A read registers the whole selected row. Reset clears only the
// read register and blocks writes on that edge.
// Assumes: wordline is one-hot.
module fm_cell_array #(
    parameter int ROWS = 64,
    parameter int COLS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] wordline,
    input  logic [COLS-1:0] col_wen,
    input  logic [COLS-1:0] col_wdata,
    input  logic            rd_en,
    output logic [COLS-1:0] rd_row_q
);

    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_sense;

    // Write enabled columns of the active row; reset suppresses writes.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (wordline[r] && col_wen[c]) begin
                        cells[r][c] <= col_wdata[c];
                    end
                end
            end
        end
    end

    // Gate each row with its word line and OR the rows onto the shared bit vector.
    always_comb begin
        row_sense = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_sense = row_sense | (cells[r] & {COLS{wordline[r]}});
        end
    end

    // Capture the selected row on reads; hold it on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_row_q <= '0;
        end else if (rd_en) begin
            rd_row_q <= row_sense;
        end
    end

endmodule

// File: rtl/folded_mem.sv
// Top level of the folded single-port memory.
// It splits the address into {row, column select}, predecodes the row,
// drives column write enables, and muxes the registered row down to a word.
// Assumes: 1 <= COL_BITS < ADDR_W. One operation per clock, chosen by we.
module folded_mem
    import folded_mem_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int COL_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int ROW_BITS = ADDR_W - COL_BITS;
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int NSEL     = 1 << COL_BITS;
    localparam int COLS     = DATA_W * NSEL;
    localparam int NGRP     = pre_groups(ROW_BITS);

    logic [ROW_BITS-1:0] row_addr;
    logic [COL_BITS-1:0] col_sel;
    logic [COL_BITS-1:0] col_sel_q;
    logic [NGRP*4-1:0]   pre_lines;
    logic [ROWS-1:0]     wordline;
    logic [COLS-1:0]     col_wen;
    logic [COLS-1:0]     col_wdata;
    logic [COLS-1:0]     rd_row_q;

    // Split the address into row and column-select fields.
    always_comb begin
        row_addr = addr[ADDR_W-1:COL_BITS];
        col_sel  = addr[COL_BITS-1:0];
    end

    fm_predecoder #(.ROW_BITS(ROW_BITS)) u_pre (
        .row_addr  (row_addr),
        .pre_lines (pre_lines)
    );

    fm_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
        .pre_lines (pre_lines),
        .wordline  (wordline)
    );

    fm_col_driver #(.DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_coldrv (
        .we        (we),
        .col_sel   (col_sel),
        .wr_data   (wr_data),
        .col_wen   (col_wen),
        .col_wdata (col_wdata)
    );

    fm_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wordline  (wordline),
        .col_wen   (col_wen),
        .col_wdata (col_wdata),
        .rd_en     (~we),
        .rd_row_q  (rd_row_q)
    );

    // Keep the column select of the last read beside the registered row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_sel_q <= '0;
        end else if (!we) begin
            col_sel_q <= col_sel;
        end
    end

    fm_col_mux #(.DATA_W(DATA_W), .COL_BITS(COL_BITS)) u_colmux (
        .row_bits (rd_row_q),
        .col_sel  (col_sel_q),
        .word     (rd_data)
    );

endmodule

// File: rtl/folded_mem_chk.sv
// Assertion checker for folded_mem, attached with bind.
// It watches the ports together with the internal word lines and column enables.
// Assumes: it is bound to folded_mem with matching parameters.
module folded_mem_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int ROWS   = 64,
    parameter int COLS   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [ROWS-1:0]   wordline,
    input logic [COLS-1:0]   col_wen
);

    logic [ADDR_W-1:0] last_wr_addr;
    logic [DATA_W-1:0] last_wr_data;
    logic              last_wr_vld;
    logic              was_reset = 1'b0;

    // Remember the most recent write since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_wr_vld  <= 1'b0;
            last_wr_addr <= '0;
            last_wr_data <= '0;
        end else if (we) begin
            last_wr_vld  <= 1'b1;
            last_wr_addr <= addr;
            last_wr_data <= wr_data;
        end
    end

    // Note whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_reset <= !rst_n;
    end

    // R6: the edge after a reset edge sees a cleared read port.
    always @(posedge clk) begin
        if (was_reset) begin
            assert_reset_clear_R6: assert (rd_data == '0);
        end
    end

    // R7: exactly one word line for any address.
    assert_one_wordline_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wordline) == 1);

    // R4: a write enables exactly one word's worth of columns; a read enables none.
    assert_word_columns_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_wen) == (we ? DATA_W : 0));

    // R5: a write cycle leaves the read port unchanged.
    assert_hold_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> $stable(rd_data));

    // R3: reading the address of the latest write returns the written word.
    assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && last_wr_vld && addr == last_wr_addr) |=> (rd_data == $past(last_wr_data)));

endmodule

bind folded_mem folded_mem_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROWS   (ROWS),
    .COLS   (COLS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .we       (we),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .wordline (wordline),
    .col_wen  (col_wen)
);

// File: tb/folded_mem_tb_top.sv
// Self-checking bench. It sweeps every address, row and column select
// against a flat model array held in the bench.
`timescale 1ns/1ps
module folded_mem_tb_top;

    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int CB   = 2;
    localparam int NW   = 1 << AW;
    localparam int NSEL = 1 << CB;
    localparam int ROWS = NW / NSEL;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          we      = 1'b0;
    logic [AW-1:0] addr    = '0;
    logic [DW-1:0] wr_data = '0;
    wire  [DW-1:0] rd_data;

    int            n_tests  = 0;
    int            n_fail   = 0;
    bit            finished = 1'b0;
    logic [DW-1:0] model [NW];

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    folded_mem #(.ADDR_W(AW), .DATA_W(DW), .COL_BITS(CB)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .we      (we),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // Compare one value and report a mismatch.
    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Data pattern that depends on the address and the pass number.
    function automatic logic [DW-1:0] pat(int a, int p);
        return DW'((a * 37 + p * 101 + 5) ^ (a >> 3));
    endfunction

    // Write one word. Starts and ends at a falling edge.
    task automatic wr(int a, logic [DW-1:0] d);
        addr    = AW'(a);
        we      = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        we       = 1'b0;
        model[a] = d;
    endtask

    // Read one word and check it. Starts and ends at a falling edge.
    task automatic rd(int a, string req);
        addr = AW'(a);
        we   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(req, rd_data, model[a]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R6: the read port is zero after reset.
        repeat (3) @(negedge clk);
        check("R6 reset value", rd_data, '0);
        rst_n = 1'b1;

        // R1, R3, R7: distinct data at every address, then read everything back.
        for (int a = 0; a < NW; a++) wr(a, pat(a, 0));
        for (int a = 0; a < NW; a++) rd(a, "R1 R3 R7 full sweep");

        // R4: after each write, every word of the same row is read back.
        for (int r = 0; r < ROWS; r++) begin
            for (int s = 0; s < NSEL; s++) begin
                wr(r * NSEL + s, pat(r * NSEL + s, 1 + s));
                for (int t = 0; t < NSEL; t++) rd(r * NSEL + t, "R4 row neighbours");
            end
        end

        // R2: the old result stays before the edge and the new word appears after it.
        rd(5, "R2 setup read");
        addr = AW'(9);
        we   = 1'b0;
        #1;
        check("R2 before edge", rd_data, model[5]);
        @(posedge clk);
        @(negedge clk);
        check("R2 after edge", rd_data, model[9]);

        // R5: the read port holds through a write to another row.
        rd(10, "R5 setup read");
        addr    = AW'(200);
        we      = 1'b1;
        wr_data = ~model[200];
        @(posedge clk);
        @(negedge clk);
        check("R5 hold during write", rd_data, model[10]);
        we         = 1'b0;
        model[200] = wr_data;
        rd(200, "R5 R3 written word");

        // R6: a mid-run reset clears the port and keeps the stored words.
        rd(77, "R6 setup read");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R6 cleared by reset", rd_data, '0);
        rst_n = 1'b1;
        rd(77, "R6 contents kept");

        // R1: boundary addresses, and back-to-back column selects within one row.
        rd(0, "R1 lowest address");
        rd(NW - 1, "R1 highest address");
        for (int t = NSEL - 1; t >= 0; t--) rd(NSEL * 3 + t, "R1 column select order");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule